// File: doc/BRIEF.md
# Platform Sleep-State Sequencer

This block follows the power state of a host platform and steps it through the sleep states. The states are fully off, soft-off, suspend-to-RAM, running and an optional low-power idle. There is also a one-cycle transitional state on every edge between two of them. The sequencer reads the host's active-low sleep indications (deep, suspend and idle), an all-core power-good input, a wake request and a wake-inhibit input. It also keeps a flag that records that the host has declared its intent to use low-power idle. From these it decides each move.

Its outputs are one-cycle event pulses for the supervisory logic around it: startup, resume, suspend and shutdown. It also gives a forced-shutdown pulse when power-good is lost, a radio mode code and a throttle output whose active level is set by a parameter. The current state is visible as a 4-bit code. Leaving fully-off can be held back by the inhibit input for a bounded number of polls. If the wait runs out, the sequencer falls back to off and records the refusal.

Top module: `pwr_seq_fsm`

## Requirements
- R1: After reset, state_o is 0 (off), rf_mode is 2'b00 (radio off), every event and force_off are low, wake_blocked is low and prochot is at its inactive level (1 when THROT_ACT_LOW is 1, 0 when it is 0).
- R2: In off (0), a high wake_req moves to the off-to-soft state (1). From state 1, a low wake_inhibit moves to soft-off (2) on the next edge and clears wake_blocked.
- R3: While wake_inhibit stays high, the sequencer spends exactly MAX_TRIES cycles in state 1 and then returns to off (0) with wake_blocked set, on the same edge.
- R4: In soft-off (2), a high slp_s4_n moves to soft-to-suspend (3). From 3 with pgood_all high, it moves to suspend (4) and ev_startup pulses. With pgood_all low, force_off pulses, it moves to soft-to-off (12), and then to off (0).
- R5: In suspend (4), rules are taken in this order. First, a low pgood_all wins: force_off pulses and the state becomes 8. Otherwise a high slp_s3_n moves to suspend-to-run (5). Otherwise a low slp_s4_n moves to suspend-to-soft (8).
- R6: From 5 with pgood_all high, the sequencer enters run (6). In the same cycle ev_resume pulses, rf_mode becomes 2'b10 (on) and prochot returns to its inactive level.
- R7: In run (6), a low pgood_all (with a force_off pulse) or a low slp_s3_n moves to run-to-suspend (7). From 7 it enters suspend (4); in that cycle ev_suspend pulses and rf_mode becomes 2'b01 (suspended).
- R8: With IDLE_EN set, run moves to run-to-idle (9) and then idle (10) only when the intent flag is set and slp_s0_n is low. A low slp_s0_n without the flag leaves the state at 6.
- R9: Idle moves to idle-to-run (11) and then run (6) only when slp_s0_n and slp_s3_n are both high. Failing that, a low pgood_all returns idle straight to run (6) without a force_off pulse.
- R10: Suspend-to-soft (8) always goes next to soft-off (2), never to off. In that cycle ev_shutdown pulses and rf_mode becomes 2'b00.
- R11: A high idle_intent_set sets the intent flag on the next edge. The flag is cleared on the edge that leaves state 3, and that clear wins over a set in the same cycle.
- R12: prochot follows throttle_req, one cycle later, only while the state is run (6). In every other state throttle_req has no effect and prochot holds its value.
- R13: Each event output is high for exactly one cycle per transition, and at most one of the four events is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_s4_n | input | 1 | Deep-sleep indication, low = asleep |
| slp_s3_n | input | 1 | Suspend indication, low = asleep |
| slp_s0_n | input | 1 | Low-power idle indication, low = idle |
| pgood_all | input | 1 | All core rails good |
| idle_intent_set | input | 1 | Host declares low-power idle intent |
| wake_req | input | 1 | Request to leave off |
| wake_inhibit | input | 1 | Power-up currently not allowed |
| throttle_req | input | 1 | Request to assert the throttle output |
| state_o | output | 4 | Encoded current state |
| ev_startup | output | 1 | Pulse: rails up, entering suspend from soft-off |
| ev_resume | output | 1 | Pulse: entering run |
| ev_suspend | output | 1 | Pulse: leaving run for suspend |
| ev_shutdown | output | 1 | Pulse: leaving suspend for soft-off |
| force_off | output | 1 | Pulse: forced shutdown on power-good loss |
| rf_mode | output | 2 | Radio mode: 00 off, 01 suspended, 10 on |
| prochot | output | 1 | Throttle output, polarity set by THROT_ACT_LOW |
| wake_blocked | output | 1 | Last power-up attempt ran out of polls |

## Verification
Two rules can land on the same cycle. The intent flag can be set by idle_intent_set in the cycle that the soft-to-suspend exit clears it. A power-good loss can also coincide with a high slp_s3_n while in suspend. The bench provokes the first by holding idle_intent_set high through state 3, then shows that a later low slp_s0_n in run leaves the state at 6. It provokes the second by dropping pgood_all and raising slp_s3_n on the same edge in suspend, and expects state 8 with a force_off pulse rather than state 5.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    PS_OFF       = 4'd0,
    PS_OFF_SOFT  = 4'd1,
    PS_SOFT      = 4'd2,
    PS_SOFT_SUSP = 4'd3,
    PS_SUSP      = 4'd4,
    PS_SUSP_ON   = 4'd5,
    PS_ON        = 4'd6,
    PS_ON_SUSP   = 4'd7,
    PS_SUSP_SOFT = 4'd8,
    PS_ON_IDLE   = 4'd9,
    PS_IDLE      = 4'd10,
    PS_IDLE_ON   = 4'd11,
    PS_SOFT_OFF  = 4'd12
  } pwr_state_e;

  typedef enum logic [1:0] {
    RF_OFF     = 2'b00,
    RF_SUSPEND = 2'b01,
    RF_ON      = 2'b10
  } rf_mode_e;

  // Decisions taken on the current edge; registered into outputs.
  typedef struct packed {
    logic startup;
    logic resume;
    logic suspend;
    logic shutdown;
    logic force_off;
    logic clr_intent;
  } seq_evt_t;

  // Pin level of the throttle output for a wanted logical state.
  function automatic logic throttle_level(input logic want, input logic act_low);
    return want ^ act_low;
  endfunction

  // True on the last permitted poll of the wake gate.
  function automatic logic last_poll(input int unsigned polls, input int unsigned limit);
    return (polls + 1) >= limit;
  endfunction

endpackage

// File: rtl/pwr_seq_next.sv
module pwr_seq_next
  import pwr_seq_pkg::*;
#(
  parameter bit IDLE_EN = 1'b1
) (
  input  pwr_state_e cur,
  input  logic       slp_s4_n,
  input  logic       slp_s3_n,
  input  logic       slp_s0_n,
  input  logic       pgood,
  input  logic       intent,
  input  logic       wake_req,
  input  logic       inhibit,
  input  logic       give_up,
  output pwr_state_e nxt,
  output seq_evt_t   evt,
  output logic       idle_gate
);

  generate
    if (IDLE_EN) begin : g_idle
      assign idle_gate = intent & ~slp_s0_n;
    end else begin : g_no_idle
      assign idle_gate = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt = cur;
    evt = '0;
    unique case (cur)
      PS_OFF: begin
        if (wake_req) nxt = PS_OFF_SOFT;
      end
      PS_OFF_SOFT: begin
        if (!inhibit)     nxt = PS_SOFT;
        else if (give_up) nxt = PS_OFF;
      end
      PS_SOFT: begin
        if (slp_s4_n) nxt = PS_SOFT_SUSP;
      end
      PS_SOFT_SUSP: begin
        evt.clr_intent = 1'b1;
        if (!pgood) begin
          nxt           = PS_SOFT_OFF;
          evt.force_off = 1'b1;
        end else begin
          nxt         = PS_SUSP;
          evt.startup = 1'b1;
        end
      end
      PS_SOFT_OFF: nxt = PS_OFF;
      PS_SUSP: begin
        if (!pgood) begin
          nxt           = PS_SUSP_SOFT;
          evt.force_off = 1'b1;
        end else if (slp_s3_n) begin
          nxt = PS_SUSP_ON;
        end else if (!slp_s4_n) begin
          nxt = PS_SUSP_SOFT;
        end
      end
      PS_SUSP_ON: begin
        if (!pgood) begin
          nxt           = PS_SUSP_SOFT;
          evt.force_off = 1'b1;
        end else begin
          nxt        = PS_ON;
          evt.resume = 1'b1;
        end
      end
      PS_ON: begin
        if (!pgood) begin
          nxt           = PS_ON_SUSP;
          evt.force_off = 1'b1;
        end else if (!slp_s3_n) begin
          nxt = PS_ON_SUSP;
        end else if (idle_gate) begin
          nxt = PS_ON_IDLE;
        end
      end
      PS_ON_SUSP: begin
        nxt         = PS_SUSP;
        evt.suspend = 1'b1;
      end
      PS_SUSP_SOFT: begin
        nxt          = PS_SOFT;
        evt.shutdown = 1'b1;
      end
      PS_ON_IDLE: nxt = PS_IDLE;
      PS_IDLE: begin
        if (slp_s0_n && slp_s3_n) nxt = PS_IDLE_ON;
        else if (!pgood)          nxt = PS_ON;
      end
      PS_IDLE_ON: nxt = PS_ON;
      default:    nxt = PS_OFF;
    endcase
  end

endmodule

// File: rtl/pwr_seq_gate.sv
module pwr_seq_gate
  import pwr_seq_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e cur,
  input  logic       inhibit,
  output logic       give_up,
  output logic       blocked
);

  localparam int unsigned CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] polls_q;
  logic          in_gate;

  assign in_gate = (cur == PS_OFF_SOFT);
  assign give_up = in_gate & inhibit & last_poll(int'(polls_q), MAX_TRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polls_q <= '0;
      blocked <= 1'b0;
    end else begin
      if (in_gate && inhibit && !give_up) polls_q <= polls_q + 1'b1;
      else                                polls_q <= '0;
      if (give_up)                 blocked <= 1'b1;
      else if (in_gate && !inhibit) blocked <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_seq_outs.sv
module pwr_seq_outs
  import pwr_seq_pkg::*;
#(
  parameter bit THROT_ACT_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e cur,
  input  seq_evt_t   evt,
  input  logic       throttle_req,
  output logic       ev_startup,
  output logic       ev_resume,
  output logic       ev_suspend,
  output logic       ev_shutdown,
  output logic       force_off,
  output rf_mode_e   rf_mode,
  output logic       prochot
);

  localparam logic PH_IDLE = throttle_level(1'b0, THROT_ACT_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_startup  <= 1'b0;
      ev_resume   <= 1'b0;
      ev_suspend  <= 1'b0;
      ev_shutdown <= 1'b0;
      force_off   <= 1'b0;
      rf_mode     <= RF_OFF;
      prochot     <= PH_IDLE;
    end else begin
      ev_startup  <= evt.startup;
      ev_resume   <= evt.resume;
      ev_suspend  <= evt.suspend;
      ev_shutdown <= evt.shutdown;
      force_off   <= evt.force_off;
      if (evt.resume)        rf_mode <= RF_ON;
      else if (evt.suspend)  rf_mode <= RF_SUSPEND;
      else if (evt.shutdown) rf_mode <= RF_OFF;
      if (evt.resume)        prochot <= PH_IDLE;
      else if (cur == PS_ON) prochot <= throttle_level(throttle_req, THROT_ACT_LOW);
    end
  end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned MAX_TRIES     = 4,
  parameter bit          IDLE_EN       = 1'b1,
  parameter bit          THROT_ACT_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_s4_n,
  input  logic       slp_s3_n,
  input  logic       slp_s0_n,
  input  logic       pgood_all,
  input  logic       idle_intent_set,
  input  logic       wake_req,
  input  logic       wake_inhibit,
  input  logic       throttle_req,
  output logic [3:0] state_o,
  output logic       ev_startup,
  output logic       ev_resume,
  output logic       ev_suspend,
  output logic       ev_shutdown,
  output logic       force_off,
  output logic [1:0] rf_mode,
  output logic       prochot,
  output logic       wake_blocked
);

  pwr_state_e state_q, state_d;
  seq_evt_t   evt;
  logic       intent_q;
  logic       give_up;
  logic       idle_gate;
  rf_mode_e   rf_q;

  pwr_seq_next #(.IDLE_EN(IDLE_EN)) u_next (
    .cur      (state_q),
    .slp_s4_n (slp_s4_n),
    .slp_s3_n (slp_s3_n),
    .slp_s0_n (slp_s0_n),
    .pgood    (pgood_all),
    .intent   (intent_q),
    .wake_req (wake_req),
    .inhibit  (wake_inhibit),
    .give_up  (give_up),
    .nxt      (state_d),
    .evt      (evt),
    .idle_gate(idle_gate)
  );

  pwr_seq_gate #(.MAX_TRIES(MAX_TRIES)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur    (state_q),
    .inhibit(wake_inhibit),
    .give_up(give_up),
    .blocked(wake_blocked)
  );

  pwr_seq_outs #(.THROT_ACT_LOW(THROT_ACT_LOW)) u_outs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur         (state_q),
    .evt         (evt),
    .throttle_req(throttle_req),
    .ev_startup  (ev_startup),
    .ev_resume   (ev_resume),
    .ev_suspend  (ev_suspend),
    .ev_shutdown (ev_shutdown),
    .force_off   (force_off),
    .rf_mode     (rf_q),
    .prochot     (prochot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_OFF;
      intent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (evt.clr_intent)       intent_q <= 1'b0;
      else if (idle_intent_set) intent_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign rf_mode = rf_q;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pwr_state_e state_q,
  input logic       intent_q,
  input logic       idle_gate,
  input logic       pgood_all,
  input logic       slp_s3_n,
  input logic       slp_s0_n,
  input logic       wake_inhibit,
  input logic       ev_startup,
  input logic       ev_resume,
  input logic       ev_suspend,
  input logic       ev_shutdown,
  input logic       force_off,
  input logic [1:0] rf_mode,
  input logic       wake_blocked
);

  a_r3_gate_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_OFF_SOFT && !wake_inhibit) |=> (state_q == PS_SOFT && !wake_blocked));

  a_r5_pgood_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SUSP && !pgood_all) |=> (state_q == PS_SUSP_SOFT && force_off));

  a_r8_no_idle_without_intent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ON && !intent_q) |=> (state_q != PS_ON_IDLE));

  a_r8_idle_gate_needs_low_s0: assert property (@(posedge clk) disable iff (!rst_n)
    idle_gate |-> (!slp_s0_n && intent_q));

  a_r9_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE && slp_s0_n && slp_s3_n) |=> (state_q == PS_IDLE_ON));

  a_r10_lands_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SUSP_SOFT) |=> (state_q == PS_SOFT && ev_shutdown && rf_mode == 2'b00));

  a_r11_intent_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SOFT_SUSP) |=> !intent_q);

  a_r13_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_startup, ev_resume, ev_suspend, ev_shutdown}));

  a_r13_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> !ev_resume);

  a_r13_startup_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_startup |=> !ev_startup);

endmodule

bind pwr_seq_fsm pwr_seq_chk i_pwr_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_q     (state_q),
  .intent_q    (intent_q),
  .idle_gate   (idle_gate),
  .pgood_all   (pgood_all),
  .slp_s3_n    (slp_s3_n),
  .slp_s0_n    (slp_s0_n),
  .wake_inhibit(wake_inhibit),
  .ev_startup  (ev_startup),
  .ev_resume   (ev_resume),
  .ev_suspend  (ev_suspend),
  .ev_shutdown (ev_shutdown),
  .force_off   (force_off),
  .rf_mode     (rf_mode),
  .wake_blocked(wake_blocked)
);

// File: tb/test_pwr_seq_fsm.sv
`timescale 1ns/1ps
module test_pwr_seq_fsm;

  localparam int TRIES = 4;
  // State codes as listed in the requirements.
  localparam logic [3:0] S_OFF = 0, S_OFFSOFT = 1, S_SOFT = 2, S_SOFTSUSP = 3, S_SUSP = 4,
                         S_SUSPON = 5, S_ON = 6, S_ONSUSP = 7, S_SUSPSOFT = 8,
                         S_ONIDLE = 9, S_IDLE = 10, S_IDLEON = 11, S_SOFTOFF = 12;
  // Throttle polarity is active-low in this bench.
  localparam logic PH_ACT = 1'b0, PH_INACT = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slp_s4_n, slp_s3_n, slp_s0_n, pgood_all, idle_intent_set, wake_req, wake_inhibit, throttle_req;
  logic [3:0] state_o;
  logic ev_startup, ev_resume, ev_suspend, ev_shutdown, force_off, prochot, wake_blocked;
  logic [1:0] rf_mode;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_seq_fsm #(.MAX_TRIES(TRIES), .IDLE_EN(1'b1), .THROT_ACT_LOW(1'b1)) i_pwr_seq_fsm (
    .clk(clk), .rst_n(rst_n), .slp_s4_n(slp_s4_n), .slp_s3_n(slp_s3_n), .slp_s0_n(slp_s0_n),
    .pgood_all(pgood_all), .idle_intent_set(idle_intent_set), .wake_req(wake_req),
    .wake_inhibit(wake_inhibit), .throttle_req(throttle_req), .state_o(state_o),
    .ev_startup(ev_startup), .ev_resume(ev_resume), .ev_suspend(ev_suspend),
    .ev_shutdown(ev_shutdown), .force_off(force_off), .rf_mode(rf_mode),
    .prochot(prochot), .wake_blocked(wake_blocked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    slp_s4_n = 0; slp_s3_n = 0; slp_s0_n = 0; pgood_all = 1;
    idle_intent_set = 0; wake_req = 0; wake_inhibit = 0; throttle_req = 0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic go_soft();
    do_reset();
    wake_req = 1; step(); wake_req = 0; step();
  endtask

  task automatic go_susp();
    go_soft();
    slp_s4_n = 1; step(); step();
  endtask

  task automatic go_on();
    go_susp();
    slp_s3_n = 1; step(); step();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 state", state_o, S_OFF);
    chk("R1 rf", rf_mode, 2'b00);
    chk("R1 events", {ev_startup, ev_resume, ev_suspend, ev_shutdown, force_off}, 0);
    chk("R1 prochot", prochot, PH_INACT);
    chk("R1 blocked", wake_blocked, 0);
  endtask

  task automatic t_inhibit();
    do_reset();
    wake_inhibit = 1; wake_req = 1; step(); wake_req = 0;
    for (int i = 1; i < TRIES; i++) begin
      chk("R3 still polling", state_o, S_OFFSOFT);
      step();
    end
    chk("R3 last poll", state_o, S_OFFSOFT);
    step();
    chk("R3 back to off", state_o, S_OFF);
    chk("R3 blocked set", wake_blocked, 1);
    wake_inhibit = 0; wake_req = 1; step(); wake_req = 0;
    chk("R2 to gate", state_o, S_OFFSOFT);
    step();
    chk("R2 to soft", state_o, S_SOFT);
    chk("R2 blocked cleared", wake_blocked, 0);
  endtask

  task automatic t_startup_intent_race();
    go_soft();
    idle_intent_set = 1; step();
    slp_s4_n = 1; step();
    chk("R4 soft to suspend", state_o, S_SOFTSUSP);
    step();
    idle_intent_set = 0;
    chk("R4 in suspend", state_o, S_SUSP);
    chk("R4 startup pulse", ev_startup, 1);
    step();
    chk("R13 startup one cycle", ev_startup, 0);
    slp_s3_n = 1; step();
    chk("R5 to resume path", state_o, S_SUSPON);
    step();
    chk("R6 in run", state_o, S_ON);
    chk("R6 resume pulse", ev_resume, 1);
    chk("R6 rf on", rf_mode, 2'b10);
    chk("R6 prochot inactive", prochot, PH_INACT);
    slp_s0_n = 0; step(); step();
    chk("R11 clear beat set, no idle", state_o, S_ON);
  endtask

  task automatic t_throttle_idle();
    go_on();
    throttle_req = 1; step();
    chk("R12 throttle asserted in run", prochot, PH_ACT);
    throttle_req = 0; step();
    chk("R12 throttle released", prochot, PH_INACT);
    slp_s0_n = 0; step();
    chk("R8 no intent ignores idle", state_o, S_ON);
    idle_intent_set = 1; step(); idle_intent_set = 0;
    step();
    chk("R8 to idle entry", state_o, S_ONIDLE);
    step();
    chk("R8 in idle", state_o, S_IDLE);
    slp_s0_n = 1; step();
    chk("R9 idle exit", state_o, S_IDLEON);
    step();
    chk("R9 back to run", state_o, S_ON);
    slp_s0_n = 0; step(); step();
    chk("R8 idle again", state_o, S_IDLE);
    pgood_all = 0; step();
    chk("R9 pgood loss to run", state_o, S_ON);
    chk("R9 no force from idle", force_off, 0);
    step();
    chk("R7 pgood loss in run", state_o, S_ONSUSP);
    chk("R7 force pulse", force_off, 1);
    step();
    chk("R7 suspend", state_o, S_SUSP);
    chk("R7 suspend pulse", ev_suspend, 1);
    chk("R7 rf suspended", rf_mode, 2'b01);
    step();
    chk("R5 pgood loss in suspend", state_o, S_SUSPSOFT);
    chk("R5 force pulse", force_off, 1);
    step();
    chk("R10 lands soft", state_o, S_SOFT);
    chk("R10 shutdown pulse", ev_shutdown, 1);
    chk("R10 rf off", rf_mode, 2'b00);
    step();
    chk("R4 soft to suspend again", state_o, S_SOFTSUSP);
    step();
    chk("R4 no rails to soft-off", state_o, S_SOFTOFF);
    chk("R4 force pulse", force_off, 1);
    chk("R4 no startup", ev_startup, 0);
    step();
    chk("R4 reaches off", state_o, S_OFF);
  endtask

  task automatic t_suspend_shutdown();
    go_on();
    slp_s3_n = 0; step();
    chk("R7 sleep request", state_o, S_ONSUSP);
    chk("R7 no force", force_off, 0);
    step();
    chk("R7 suspend", state_o, S_SUSP);
    chk("R7 suspend pulse", ev_suspend, 1);
    throttle_req = 1; step();
    chk("R12 ignored outside run", prochot, PH_INACT);
    chk("R13 suspend one cycle", ev_suspend, 0);
    throttle_req = 0;
    slp_s4_n = 0; step();
    chk("R5 deep sleep to soft", state_o, S_SUSPSOFT);
    step();
    chk("R10 soft", state_o, S_SOFT);
    chk("R10 shutdown", ev_shutdown, 1);
    step();
    chk("R10 stays soft", state_o, S_SOFT);
  endtask

  task automatic t_susp_priority();
    go_susp();
    pgood_all = 0; slp_s3_n = 1; step();
    chk("R5 pgood beats resume", state_o, S_SUSPSOFT);
    chk("R5 force", force_off, 1);
    chk("R13 one event max", ev_startup + ev_resume + ev_suspend + ev_shutdown, 0);
  endtask

  initial begin
    t_reset_state();
    t_inhibit();
    t_startup_intent_race();
    t_throttle_idle();
    t_suspend_shutdown();
    t_susp_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule